// File: doc/BRIEF.md
# Receive Ring Engine

This block writes received frames into host memory. Two rings in memory drive it. One ring holds free buffers that software provides. The other ring holds the status entries that the engine posts back. Frame bytes arrive as a stream that carries an end-of-frame marker and per-frame error flags.

When a frame begins, the engine reads the next two-word buffer descriptor through a word-wide memory port. It then stores the frame bytes in that buffer as little-endian words. After the last byte it posts a two-word status entry and raises the receive interrupt.

Software configures each ring with a base address and a byte length. It hands entries back by writing a count to that ring's enqueue register. If either ring has no free entry, the engine consumes the frame and writes nothing. It flags the loss in the next status entry it posts.

Top module: `rx_ring_engine`

## Requirements
- R1: A descriptor is two words, read at the descriptor current address and that address plus 4. Word 0 is the buffer address. Word 1 bits 30:16 are the buffer index and bits 15:0 the buffer length. Frame byte k goes to byte lane k mod 4 of the word at buffer address + 4*(k div 4).
- R2: The write limit is the smaller of the buffer length and MAX_LEN. Bytes at or beyond the limit are not stored, and lanes above the limit in a partly filled word are written as zero. A frame longer than the limit has its good bit cleared.
- R3: Status word 0 has the following bits. Bit 31 = 1 (processed). Bit 30 = good (no CRC error, no framing error, not a runt, not over the limit). Bits 29 and 28 = 1. Bit 20 = overrun. Bit 19 = framing error. Bit 18 = runt. Bit 16 = CRC error. Bit 15 = 1 (CRC bytes kept). All other bits are 0.
- R4: Status word 1 has bit 31 = 1, bits 30:16 = the buffer index from the descriptor, and bits 15:0 = the number of frame bytes received.
- R5: The status entry is written only after the last byte has been accepted. Word 0 goes to the status current address and word 1 to that address plus 4.
- R6: Each posted frame advances both current addresses by 8. A current address that would reach base + ring length returns to base. Writing a base register also loads its current address.
- R7: Writing N to a ring's enqueue register adds N to that ring's available count. Each posted frame subtracts one from both counts.
- R8: If either available count is zero when a frame starts, the engine consumes the whole frame. It makes no memory access, and counts and current addresses stay unchanged. The next posted status then has bit 20 set, and the status after that has it clear.
- R9: `irq` goes high when a status entry is posted. Writing a word with bit 2 set to the clear register (select 6) drops it.
- R10: A frame shorter than MIN_LEN bytes sets bit 18 and clears bit 30.
- R11: After reset, `irq` is 0, both available counts and both current addresses are 0, and `in_ready` is 0. `in_ready` is high only while a frame is being stored or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 desc base, 1 desc ring bytes, 2 status base, 3 status ring bytes, 4 desc enqueue, 5 status enqueue, 6 interrupt clear |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame byte valid |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_frm_err | input | 1 | Framing error, sampled with the last byte |
| in_ready | output | 1 | Byte accepted on this edge when valid |
| mem_rd | output | 1 | Memory read; data returns combinationally |
| mem_we | output | 1 | Memory word write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| desc_cur | output | 32 | Descriptor ring current address |
| stat_cur | output | 32 | Status ring current address |
| desc_avail | output | CNT_W | Descriptors available to the engine |
| stat_avail | output | CNT_W | Status slots available to the engine |
| irq | output | 1 | Receive status posted |

## Verification
The bench builds the engine with MAX_LEN = 16, MIN_LEN = 8 and an 8-bit count width, and uses four-entry rings. With this small configuration, a sweep of every frame length from 1 to 20 bytes reaches the runt, nominal and over-limit cases, every partial last word, and the ring wrap, which comes every fourth frame. A 10-byte buffer length puts the write limit in the middle of a word. Exhausting each ring in turn exercises the drop path and the overrun bit that follows it.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int CNT_W   = 16,
  parameter int MAX_LEN = 2044,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             in_crc_err,
  input  logic             in_frm_err,
  output logic             in_ready,
  output logic             mem_rd,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [31:0]      desc_cur,
  output logic [31:0]      stat_cur,
  output logic [CNT_W-1:0] desc_avail,
  output logic [CNT_W-1:0] stat_avail,
  output logic             irq
);
  localparam logic [15:0] MAXL = 16'(MAX_LEN);
  localparam logic [15:0] MINL = 16'(MIN_LEN);

  typedef enum logic [2:0] {IDLE, D0, D1, RECV, DROP, ST0, ST1} st_t;
  st_t st;

  logic [31:0] desc_base, stat_base, buf_addr, acc;
  logic [15:0] desc_len, stat_len, buf_len, bcnt;
  logic [14:0] buf_idx;
  logic        crc_f, frm_f, ovr_pend;

  logic        take, word_we, runt, over, good, post;
  logic [1:0]  lane;
  logic [15:0] cap;
  logic [31:0] ins, w0, w1, d_next, s_next;

  assign in_ready = (st == RECV) || (st == DROP);
  assign take     = in_valid && in_ready;
  assign lane     = bcnt[1:0];
  assign cap      = (buf_len < MAXL) ? buf_len : MAXL;
  assign ins      = (bcnt < cap) ? ({24'b0, in_byte} << {lane, 3'b000}) : 32'b0;
  assign word_we  = (st == RECV) && take && (lane == 2'd3 || in_last) && ({bcnt[15:2], 2'b00} < cap);
  assign runt     = bcnt < MINL;
  assign over     = bcnt > cap;
  assign good     = !(crc_f || frm_f || runt || over);
  assign post     = (st == ST1);
  assign w0 = {1'b1, good, 2'b11, 7'b0, ovr_pend, frm_f, runt, 1'b0, crc_f, 1'b1, 15'b0};
  assign w1 = {1'b1, buf_idx, bcnt};
  assign d_next = (desc_cur + 32'd8 >= desc_base + {16'b0, desc_len}) ? desc_base : desc_cur + 32'd8;
  assign s_next = (stat_cur + 32'd8 >= stat_base + {16'b0, stat_len}) ? stat_base : stat_cur + 32'd8;

  assign mem_rd    = (st == D0) || (st == D1);
  assign mem_we    = word_we || (st == ST0) || (st == ST1);
  assign mem_wdata = (st == ST0) ? w0 : (st == ST1) ? w1 : (acc | ins);

  always_comb begin
    case (st)
      D0:      mem_addr = desc_cur;
      D1:      mem_addr = desc_cur + 32'd4;
      ST0:     mem_addr = stat_cur;
      ST1:     mem_addr = stat_cur + 32'd4;
      default: mem_addr = buf_addr + {16'b0, bcnt[15:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; buf_addr <= '0; buf_idx <= '0; buf_len <= '0; bcnt <= '0; acc <= '0;
      crc_f <= 1'b0; frm_f <= 1'b0; ovr_pend <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          bcnt <= '0; acc <= '0;
          if (in_valid) st <= (desc_avail != 0 && stat_avail != 0) ? D0 : DROP;
        end
        D0: begin buf_addr <= mem_rdata; st <= D1; end
        D1: begin buf_idx <= mem_rdata[30:16]; buf_len <= mem_rdata[15:0]; st <= RECV; end
        RECV: if (take) begin
          bcnt <= bcnt + 16'd1;
          acc  <= (lane == 2'd3) ? 32'b0 : (acc | ins);
          if (in_last) begin crc_f <= in_crc_err; frm_f <= in_frm_err; st <= ST0; end
        end
        DROP: if (take && in_last) begin ovr_pend <= 1'b1; st <= IDLE; end
        ST0: st <= ST1;
        default: begin ovr_pend <= 1'b0; st <= IDLE; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_base <= '0; stat_base <= '0; desc_len <= '0; stat_len <= '0;
      desc_cur <= '0; stat_cur <= '0; desc_avail <= '0; stat_avail <= '0; irq <= 1'b0;
    end else begin
      desc_avail <= desc_avail + ((reg_we && reg_sel == 3'd4) ? reg_wdata[CNT_W-1:0] : '0) - CNT_W'(post);
      stat_avail <= stat_avail + ((reg_we && reg_sel == 3'd5) ? reg_wdata[CNT_W-1:0] : '0) - CNT_W'(post);
      if (post) begin desc_cur <= d_next; stat_cur <= s_next; end
      if (reg_we && reg_sel == 3'd6 && reg_wdata[2]) irq <= 1'b0;
      if (post) irq <= 1'b1;
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin desc_base <= reg_wdata; desc_cur <= reg_wdata; end
          3'd1: desc_len <= reg_wdata[15:0];
          3'd2: begin stat_base <= reg_wdata; stat_cur <= reg_wdata; end
          3'd3: stat_len <= reg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  AST_RECV_HAS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RECV) |-> (desc_avail != 0 && stat_avail != 0)); // R8
  AST_STATUS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST0) |-> $past(st == RECV && in_valid && in_last)); // R5
  AST_IRQ_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(st == ST1)); // R9
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DROP) |-> (!mem_we && !mem_rd)); // R8
  AST_DATA_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RECV && mem_we) |-> ((mem_addr - buf_addr) < {16'b0, MAXL})); // R2
endmodule

// File: tb/rx_ring_engine_tb.sv
module rx_ring_engine_tb_top;
  localparam int CLK_NS = 10;
  localparam int CW = 8;
  localparam int MAXL = 16;
  localparam int MINL = 8;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic in_valid = 0, in_last = 0, in_crc_err = 0, in_frm_err = 0; logic [7:0] in_byte = 0;
  logic in_ready, mem_rd, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, desc_cur, stat_cur;
  logic [CW-1:0] desc_avail, stat_avail;
  logic [31:0] mem [0:255];

  int errs = 0, checks = 0, fr = 0, de = 0, se = 0, ea = 0, es = 0;

  rx_ring_engine #(.CNT_W(CW), .MAX_LEN(MAXL), .MIN_LEN(MINL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last), .in_crc_err(in_crc_err),
    .in_frm_err(in_frm_err), .in_ready(in_ready), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .desc_cur(desc_cur),
    .stat_cur(stat_cur), .desc_avail(desc_avail), .stat_avail(stat_avail), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin errs++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk); reg_we = 1; reg_sel = 3'(sel); reg_wdata = 32'(val);
    @(negedge clk); reg_we = 0;
  endtask

  function automatic logic [7:0] dbyte(input int f, input int k);
    return 8'((f * 37 + k * 3 + 1) & 255);
  endfunction

  task automatic send(input int len, input bit crc, input bit fe);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_byte = dbyte(fr, k); in_last = (k == len - 1);
      in_crc_err = crc; in_frm_err = fe;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
    end
    @(negedge clk); in_valid = 0; in_last = 0; in_crc_err = 0; in_frm_err = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input int len, input int blen, input bit crc, input bit fe, input bit ovr);
    int cap, nw, sa; logic [31:0] w, e0;
    mem[de * 2]     = 32'h100 + 32'(de * 64);
    mem[de * 2 + 1] = (32'(de + 16) << 16) | 32'(blen);
    for (int j = 0; j < 16; j++) mem[64 + de * 16 + j] = 32'hDEADBEEF;
    sa = 16 + se * 2; mem[sa] = 0; mem[sa + 1] = 0;
    cap = (blen < MAXL) ? blen : MAXL;
    nw = (((len < cap) ? len : cap) + 3) / 4;
    send(len, crc, fe);
    for (int j = 0; j < nw; j++) begin
      w = 0;
      for (int b = 0; b < 4; b++)
        if (4*j + b < len && 4*j + b < cap) w |= {24'b0, dbyte(fr, 4*j + b)} << (8*b);
      chk("R1 data word", mem[64 + de * 16 + j], w);
    end
    if (nw < 16) chk("R2 word past limit", mem[64 + de * 16 + nw], 32'hDEADBEEF);
    e0 = 32'hB000_8000;
    if (!(crc || fe || len < MINL || len > cap)) e0 |= 32'h4000_0000;
    if (ovr) e0 |= 32'h0010_0000;
    if (fe) e0 |= 32'h0008_0000;
    if (len < MINL) e0 |= 32'h0004_0000;
    if (crc) e0 |= 32'h0001_0000;
    chk("R3 R10 status word0", mem[sa], e0);
    chk("R4 status word1", mem[sa + 1], 32'h8000_0000 | (32'(de + 16) << 16) | 32'(len));
    de = (de + 1) % 4; se = (se + 1) % 4; ea--; es--;
    chk("R6 desc_cur", desc_cur, 32'(de * 8));
    chk("R6 stat_cur", stat_cur, 32'h40 + 32'(se * 8));
    chk("R7 desc_avail", 32'(desc_avail), 32'(ea));
    chk("R7 stat_avail", 32'(stat_avail), 32'(es));
    chk("R9 irq set", 32'(irq), 1);
    wr(6, 4);
    chk("R9 irq cleared", 32'(irq), 0);
    fr++;
  endtask

  task automatic drop_frame(input int len);
    logic [31:0] dc, sc;
    dc = desc_cur; sc = stat_cur;
    mem[16 + se * 2] = 0;
    send(len, 0, 0);
    chk("R8 status slot untouched", mem[16 + se * 2], 0);
    chk("R8 desc_cur held", desc_cur, dc);
    chk("R8 stat_cur held", stat_cur, sc);
    chk("R8 desc_avail held", 32'(desc_avail), 32'(ea));
    chk("R8 stat_avail held", 32'(stat_avail), 32'(es));
    chk("R8 no irq", 32'(irq), 0);
    fr++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset irq", 32'(irq), 0);
    chk("R11 reset desc_avail", 32'(desc_avail), 0);
    chk("R11 reset stat_cur", stat_cur, 0);
    chk("R11 reset in_ready", 32'(in_ready), 0);
    rst_n = 1;
    wr(0, 0); wr(1, 32); wr(2, 32'h40); wr(3, 32);
    chk("R6 base loads cur", stat_cur, 32'h40);
    wr(4, 3); wr(5, 3); wr(4, 1); wr(5, 1); ea = 4; es = 4;
    chk("R7 enqueue sum", 32'(desc_avail), 4);
    chk("R11 idle in_ready", 32'(in_ready), 0);
    for (int len = 1; len <= 20; len++) begin
      run_frame(len, 64, (len % 5 == 0), (len % 7 == 0), 0);
      wr(4, 1); wr(5, 1); ea++; es++;
    end
    for (int len = 9; len <= 13; len += 2) begin
      run_frame(len, 10, 0, 0, 0);
      wr(4, 1); wr(5, 1); ea++; es++;
    end
    for (int i = 0; i < 4; i++) run_frame(8 + i, 64, 0, 0, 0);
    drop_frame(6);
    wr(4, 1); ea++;
    drop_frame(9);
    wr(5, 1); es++;
    run_frame(12, 64, 0, 0, 1);
    wr(4, 1); wr(5, 1); ea++; es++;
    run_frame(12, 64, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule